// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block performs the single-bit shift and rotate work of a small processor datapath. It takes one operand, the current carry flag, the current zero, negative and overflow flags, and a three-bit operation code. It produces a shifted or rotated result together with new Z, C, N and V flags. The operations are logical shift left and right, rotate left and right with the carry acting as an extra bit, arithmetic shift right, and exchange of the two halves of the operand.

The result and flags are computed in one combinational stage and are captured into output registers on a rising clock edge when the enable input is high. A new operation can therefore be issued every clock. Flags that the selected operation does not define are copied from the flag inputs, so the caller can feed the registered flags straight back in. A sign output, N xor V of the registered flags, is provided for the surrounding logic.

Top module: `shift_rotate_unit`

## Requirements
- R1: While rst_n is low at a rising edge, res_q, all flag outputs and sign_q become 0.
- R2: Code 0 (shift left) gives res = operand shifted up one place with 0 in bit 0, and C = old operand bit 7.
- R3: Code 1 (logical shift right) gives res = operand shifted down one place with 0 in bit 7, and C = old operand bit 0.
- R4: Code 2 (rotate left) gives res = operand shifted up one place with carry_in in bit 0, and C = old operand bit 7.
- R5: Code 3 (rotate right) gives res = operand shifted down one place with carry_in in bit 7, and C = old operand bit 0.
- R6: Code 4 (arithmetic shift right) gives res = operand shifted down one place with old bit 7 kept in bit 7, and C = old operand bit 0.
- R7: For codes 0 to 4, Z is 1 exactly when the result is zero, N equals result bit 7, and V equals N xor C of the new flags.
- R8: Code 5 gives res = {operand[3:0], operand[7:4]} and Z, C, N, V equal the flag inputs unchanged.
- R9: Codes 6 and 7 give res = operand and Z, C, N, V equal the flag inputs unchanged.
- R10: With en high at a rising edge the new result and flags appear at the outputs after that edge; with en low the outputs hold their previous values.
- R11: sign_q always equals flag_n_q xor flag_v_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Capture enable for result and flags |
| op_sel | input | 3 | Operation code (0..7) |
| operand | input | W | Operand to shift or rotate |
| flag_z_i | input | 1 | Current zero flag |
| flag_c_i | input | 1 | Current carry flag, also the rotate input bit |
| flag_n_i | input | 1 | Current negative flag |
| flag_v_i | input | 1 | Current overflow flag |
| res_q | output | W | Registered result |
| flag_z_q | output | 1 | Registered zero flag |
| flag_c_q | output | 1 | Registered carry flag |
| flag_n_q | output | 1 | Registered negative flag |
| flag_v_q | output | 1 | Registered overflow flag |
| sign_q | output | 1 | N xor V of the registered flags |

## Verification
The bench builds the unit with its default width of 8, which keeps the operand space small enough to sweep every operand against every operation code and both carry values. That sweep reaches all edge bits: zero results from shifting out a single set bit, the arithmetic shift of 0x80, rotates that move the carry into an empty operand, and the reserved codes. Flag inputs and the enable are randomized with a fixed seed during the sweep and a further random phase, so the pass-through of flags on swap and reserved codes and the hold behaviour are seen with many flag patterns.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
// Shared types for the shift and rotate unit: operation codes and the
// flag bundle. Assumes a three-bit operation select.
package sru_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_RTL  = 3'd2,
        OP_RTR  = 3'd3,
        OP_SAR  = 3'd4,
        OP_HSWP = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } sru_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } sru_flags_t;

    // True for the five operations that recompute the flags.
    function automatic logic op_sets_flags(sru_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_RTL) ||
               (op == OP_RTR) || (op == OP_SAR);
    endfunction

endpackage

// File: rtl/sru_shifter.sv
`timescale 1ns/1ps
// Combinational data path: builds the one-place-up and one-place-down
// vectors and selects among them, the half swap and pass-through.
// Assumes W is even so the half swap splits evenly.
module sru_shifter
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout
);
    localparam int HALF = W / 2;

    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;
    logic         up_fill;
    logic         dn_fill;

    // Pick the bit entering at the vacated end for each direction.
    always_comb begin
        up_fill = (op == OP_RTL) ? cin : 1'b0;
        unique case (op)
            OP_RTR:  dn_fill = cin;
            OP_SAR:  dn_fill = a[W-1];
            default: dn_fill = 1'b0;
        endcase
    end

    // Per-bit wiring of the shifted vectors.
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_lo
                assign up_v[i] = up_fill;
            end else begin : g_lo_mid
                assign up_v[i] = a[i-1];
            end
            if (i == W - 1) begin : g_hi
                assign dn_v[i] = dn_fill;
            end else begin : g_hi_mid
                assign dn_v[i] = a[i+1];
            end
        end
    endgenerate

    // Select the result and the bit leaving the operand.
    always_comb begin
        unique case (op)
            OP_SHL, OP_RTL: begin
                y    = up_v;
                cout = a[W-1];
            end
            OP_SHR, OP_RTR, OP_SAR: begin
                y    = dn_v;
                cout = a[0];
            end
            OP_HSWP: begin
                y    = {a[HALF-1:0], a[W-1:HALF]};
                cout = cin;
            end
            default: begin
                y    = a;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/sru_flags.sv
`timescale 1ns/1ps
// Flag generation: recomputes Z, C, N, V for the shift and rotate
// operations and passes the incoming flags through for all others.
// Assumes the data path supplies the bit that left the operand.
module sru_flags
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e      op,
    input  logic [W-1:0] y,
    input  logic         cout,
    input  sru_flags_t   fin,
    output sru_flags_t   fout
);
    // Build the new flag set or keep the old one.
    always_comb begin
        if (op_sets_flags(op)) begin
            fout.z = ~|y;
            fout.c = cout;
            fout.n = y[W-1];
            fout.v = y[W-1] ^ cout;
        end else begin
            fout = fin;
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
// Registered shift and rotate unit. Computes result and flags in one
// combinational stage and captures them when en is high. Synchronous
// active-low reset clears all outputs. Assumes W is even.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [OP_W-1:0]     op_sel,
    input  logic [W-1:0]        operand,
    input  logic                flag_z_i,
    input  logic                flag_c_i,
    input  logic                flag_n_i,
    input  logic                flag_v_i,
    output logic [W-1:0]        res_q,
    output logic                flag_z_q,
    output logic                flag_c_q,
    output logic                flag_n_q,
    output logic                flag_v_q,
    output logic                sign_q
);
    sru_op_e      op;
    sru_flags_t   flags_in;
    sru_flags_t   flags_nxt;
    sru_flags_t   flags_r;
    logic [W-1:0] res_nxt;
    logic         carry_out;

    assign op       = sru_op_e'(op_sel);
    assign flags_in = '{z: flag_z_i, c: flag_c_i, n: flag_n_i, v: flag_v_i};

    sru_shifter #(.W(W)) u_shift (
        .op   (op),
        .a    (operand),
        .cin  (flag_c_i),
        .y    (res_nxt),
        .cout (carry_out)
    );

    sru_flags #(.W(W)) u_flags (
        .op   (op),
        .y    (res_nxt),
        .cout (carry_out),
        .fin  (flags_in),
        .fout (flags_nxt)
    );

    // Output register for result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_r <= '0;
        end else if (en) begin
            res_q   <= res_nxt;
            flags_r <= flags_nxt;
        end
    end

    assign flag_z_q = flags_r.z;
    assign flag_c_q = flags_r.c;
    assign flag_n_q = flags_r.n;
    assign flag_v_q = flags_r.v;
    assign sign_q   = flags_r.n ^ flags_r.v;

endmodule

// File: rtl/sru_checker.sv
`timescale 1ns/1ps
// Property checker for shift_rotate_unit, attached by bind. Observes the
// top-level ports only.
module sru_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [2:0]   op_sel,
    input logic [W-1:0] operand,
    input logic         flag_z_i,
    input logic         flag_c_i,
    input logic         flag_n_i,
    input logic         flag_v_i,
    input logic [W-1:0] res_q,
    input logic         flag_z_q,
    input logic         flag_c_q,
    input logic         flag_n_q,
    input logic         flag_v_q,
    input logic         sign_q
);
    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0) && !flag_z_q && !flag_c_q && !flag_n_q && !flag_v_q);

    // R10: outputs hold while en is low
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(res_q) && $stable({flag_z_q, flag_c_q, flag_n_q, flag_v_q}));

    // R7: flag relations after a shift or rotate
    a_r7_flag_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel <= 3'd4) |=> (flag_z_q == (res_q == '0)) &&
                                   (flag_n_q == res_q[W-1]) &&
                                   (flag_v_q == (flag_n_q ^ flag_c_q)));

    // R4: rotate left brings the old carry into bit 0
    a_r4_rot_in: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel == 3'd2) |=> res_q[0] == $past(flag_c_i));

    // R8: half swap keeps the incoming flags
    a_r8_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel == 3'd5) |=> {flag_z_q, flag_c_q, flag_n_q, flag_v_q} ==
                                  $past({flag_z_i, flag_c_i, flag_n_i, flag_v_i}));

    // R11: sign output tracks N xor V
    a_r11_sign: assert property (@(posedge clk) disable iff (!rst_n)
        sign_q == (flag_n_q ^ flag_v_q));

endmodule

bind shift_rotate_unit sru_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .op_sel   (op_sel),
    .operand  (operand),
    .flag_z_i (flag_z_i),
    .flag_c_i (flag_c_i),
    .flag_n_i (flag_n_i),
    .flag_v_i (flag_v_i),
    .res_q    (res_q),
    .flag_z_q (flag_z_q),
    .flag_c_q (flag_c_q),
    .flag_n_q (flag_n_q),
    .flag_v_q (flag_v_q),
    .sign_q   (sign_q)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] operand = 8'h00;
    logic       fz = 1'b0, fc = 1'b0, fn = 1'b0, fv = 1'b0;
    logic [7:0] res_q;
    logic       z_q, c_q, n_q, v_q, s_q;

    int checks = 0;
    int errors = 0;
    logic [12:0] exp_st = '0;   // {res, z, c, n, v, s}

    always #5 clk = ~clk;

    shift_rotate_unit #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .operand(operand),
        .flag_z_i(fz), .flag_c_i(fc), .flag_n_i(fn), .flag_v_i(fv),
        .res_q(res_q), .flag_z_q(z_q), .flag_c_q(c_q), .flag_n_q(n_q),
        .flag_v_q(v_q), .sign_q(s_q)
    );

    // Expected {res, z, c, n, v, s} from the requirements.
    function automatic logic [12:0] model(logic [2:0] op, logic [7:0] a,
                                          logic [3:0] fi);
        logic [7:0] r;
        logic z, c, n, v;
        {z, c, n, v} = fi;
        case (op)
            3'd0: begin r = {a[6:0], 1'b0};  c = a[7]; end
            3'd1: begin r = {1'b0, a[7:1]};  c = a[0]; end
            3'd2: begin r = {a[6:0], fi[2]}; c = a[7]; end
            3'd3: begin r = {fi[2], a[7:1]}; c = a[0]; end
            3'd4: begin r = {a[7], a[7:1]};  c = a[0]; end
            3'd5: r = {a[3:0], a[7:4]};
            default: r = a;
        endcase
        if (op <= 3'd4) begin
            z = (r == 8'h00);
            n = r[7];
            v = n ^ c;
        end
        return {r, z, c, n, v, n ^ v};
    endfunction

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%h zcnv s=%b expected res=%h zcnv s=%b",
                     tag, act[12:5], act[4:0], exp[12:5], exp[4:0]);
        end
    endtask

    function automatic logic [12:0] actual();
        return {res_q, z_q, c_q, n_q, v_q, s_q};
    endfunction

    // Drive one operation, then check the registered outputs.
    task automatic step(logic e, logic [2:0] op, logic [7:0] a, logic [3:0] fi);
        @(negedge clk);
        en = e; op_sel = op; operand = a; {fz, fc, fn, fv} = fi;
        @(negedge clk);
        if (e) begin
            exp_st = model(op, a, fi);
            check(tag_of(op), actual(), exp_st);
            if (op <= 3'd4)
                check("R7", {8'h00, z_q, 1'b0, n_q, v_q, 1'b0},
                      {8'h00, exp_st[4], 1'b0, exp_st[2], exp_st[1], 1'b0});
        end else begin
            check("R10", actual(), exp_st);
        end
        check("R11", {12'h000, s_q}, {12'h000, n_q ^ v_q});
    endtask

    initial begin : watchdog
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        // R1: drive nonzero inputs through reset, outputs must stay zero
        en = 1'b1; op_sel = 3'd3; operand = 8'hFF; {fz, fc, fn, fv} = 4'b1111;
        repeat (3) @(negedge clk);
        check("R1", actual(), 13'h0000);
        rst_n = 1'b1;
        en = 1'b0;

        // Directed corner cases
        step(1'b1, 3'd0, 8'h80, 4'b0000);  // R2 result zero, C=1, V=1
        check("R2", actual(), {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1});
        step(1'b1, 3'd4, 8'h80, 4'b0000);  // R6 keeps sign bit
        check("R6", actual(), {8'hC0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
        step(1'b1, 3'd3, 8'h01, 4'b0100);  // R5 carry into bit 7
        check("R5", actual(), {8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
        step(1'b1, 3'd2, 8'h00, 4'b0100);  // R4 carry into empty operand
        check("R4", actual(), {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        step(1'b1, 3'd1, 8'h01, 4'b1010);  // R3 shift out last bit
        check("R3", actual(), {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1});
        step(1'b1, 3'd5, 8'hA5, 4'b1011);  // R8 swap keeps flags
        check("R8", actual(), {8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
        step(1'b1, 3'd6, 8'h3C, 4'b0110);  // R9 reserved code
        check("R9", actual(), {8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
        step(1'b1, 3'd7, 8'h00, 4'b1001);  // R9 reserved code
        step(1'b0, 3'd0, 8'hFF, 4'b1111);  // R10 hold

        // Full sweep with random flag inputs and enable
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++) begin
                    logic [3:0] fi = 4'($urandom());
                    fi[2] = ci[0];
                    step(($urandom() % 8) != 0, op[2:0], a[7:0], fi);
                end

        // Random phase
        for (int k = 0; k < 2000; k++)
            step(($urandom() % 4) != 0, 3'($urandom()), 8'($urandom()), 4'($urandom()));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule